// File: doc/BRIEF.md
# Fat-Tree Up/Down Cut-Through Switch

This block is a single switch node of a tree-shaped packet network. It has five bidirectional ports. Ports 0 to 3 face the four child subtrees. Port 4 faces the parent, toward the root. A packet is a run of words on a valid/ready stream, and a `last` flag marks its final word. The first word of a packet is the header, and the low byte of the header carries the destination address. The switch compares the upper bits of that address with its own subtree prefix. When they match, the packet descends to the child picked by the next two address bits. When they do not match, the packet climbs to the parent. Routing therefore depends only on the tree: a packet rises until it meets a common ancestor of its destination, then follows the single path down.

Forwarding is cut-through. Once an output has been granted to an input, each word moves into that output's small queue as soon as it arrives, without waiting for the rest of the packet. The output stays tied to that input until the flagged last word has gone in, so packets never interleave on a link. When several headers compete for a free output, a rotating priority decides. A full output queue stalls only the input that owns it.

Top module: `fts_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` and every `in_ready` is low.
- R2: A header whose destination byte (header bits [7:0]) has bits [ADDR_W-1:2*LEVEL+2] equal to `PREFIX` is delivered on down port `dest[2*LEVEL+1:2*LEVEL]` (ports 0 to 3). With the defaults this means destination 0xA0 to 0xAF, child = bits [3:2].
- R3: A header whose destination bits [ADDR_W-1:2*LEVEL+2] differ from `PREFIX` is delivered on up port 4. This holds whichever input it came in on.
- R4: Forwarding is cut-through. The header of a packet longer than the output queue leaves the output before the input has handed over the packet's last word.
- R5: An output, once granted, carries only the owning packet's words until its last word. Packets from different inputs never interleave on one output.
- R6: When two inputs each keep a header waiting for the same output, successive grants alternate between them (rotating priority, not fixed priority).
- R7: Each output holds a queue of `DEPTH` (default 4) words. With the output stalled, the owning input has exactly `DEPTH` words accepted and is then held off. A stalled output keeps its word and `last` flag stable.
- R8: A packet of one word (header with `last` set) is forwarded and releases the output at once, so later packets to that output also pass.
- R9: Every word of a packet appears on its output once, unchanged and in order, with `last` set only on the final word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Per-input word valid (bit p is port p) |
| in_data | input | 5*W | Per-input word, port p at bits [p*W +: W] |
| in_last | input | 5 | Per-input last-word flag |
| in_ready | output | 5 | Per-input word accepted this cycle when valid |
| out_valid | output | 5 | Per-output word valid |
| out_data | output | 5*W | Per-output word, port p at bits [p*W +: W] |
| out_last | output | 5 | Per-output last-word flag |
| out_ready | input | 5 | Per-output downstream acceptance |

## Verification
The routing rule is tried with a sweep in which every input sends to each of the four children and to non-local addresses. This separates the down and up decisions, and it also checks that a packet entering from the parent is routed like any other. Long packets sent into a stalled output tell cut-through forwarding apart from store-and-forward, and they expose the exact queue depth at which backpressure starts. Two inputs that keep a stream of headers aimed at one output tell rotating priority apart from fixed priority. Bursts of single-word packets mixed with long packets, and a phase with random output stalls and random destinations and lengths, stress lock release and show any interleaving or corruption of words.

// File: rtl/fts_pkg.sv
// Shared constants and helpers for the fat-tree switch.
// Assumes exactly four child ports (indices 0..3) and one parent port (index 4).
package fts_pkg;
    localparam int N_DOWN  = 4;
    localparam int N_PORT  = N_DOWN + 1;
    localparam int UP_PORT = N_DOWN;
    localparam int PIDX_W  = $clog2(N_PORT);

    typedef logic [PIDX_W-1:0] port_idx_t;

    // Convert a one-hot grant vector to a port index (0 when empty).
    function automatic port_idx_t onehot_to_idx(input logic [N_PORT-1:0] oh);
        port_idx_t r;
        r = '0;
        for (int k = 0; k < N_PORT; k++) begin
            if (oh[k]) r = port_idx_t'(k);
        end
        return r;
    endfunction
endpackage

// File: rtl/fts_route_decode.sv
// Destination decoder: maps a header destination address to an output port.
// Assumes ADDR_W > 2*LEVEL+2. Local (prefix match) -> child by two address
// bits; otherwise -> parent port.
module fts_route_decode
    import fts_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEVEL  = 1,
    parameter int PREFIX = 10
) (
    input  logic [ADDR_W-1:0] dest,
    output port_idx_t         port
);
    localparam int SEL_LSB = 2 * LEVEL;
    localparam int PFX_LSB = SEL_LSB + 2;
    localparam int PFX_W   = ADDR_W - PFX_LSB;

    // Pick the child port on a prefix match, the parent port otherwise.
    always_comb begin
        if (dest[ADDR_W-1:PFX_LSB] == PFX_W'(PREFIX)) begin
            port = port_idx_t'(dest[SEL_LSB +: 2]);
        end else begin
            port = port_idx_t'(UP_PORT);
        end
    end
endmodule

// File: rtl/fts_rr_arb.sv
// Rotating-priority arbiter. The grant is combinational from req. After each
// grant the pointer moves just past the winner. Assumes the caller takes
// every grant it is given.
module fts_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    int            win;
    int            idx;

    // Search the requests starting at the pointer; first hit wins.
    always_comb begin
        grant = '0;
        win   = -1;
        idx   = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (win < 0 && req[idx]) begin
                win        = idx;
                grant[idx] = 1'b1;
            end
        end
    end

    // Advance the priority pointer past the latest winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (win >= 0) begin
            ptr <= PW'((win + 1) % N);
        end
    end
endmodule

// File: rtl/fts_out_fifo.sv
// Output queue of DEPTH words with their last flags. Pushes are accepted only
// when not full (the switch never pushes into a full queue); pop is
// valid && ready.
module fts_out_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         push_last,
    input  logic         pop_ready,
    output logic         valid,
    output logic [W-1:0] data,
    output logic         last,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign valid   = (count != '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = valid && pop_ready;
    assign data    = mem[rd_ptr][W-1:0];
    assign last    = mem[rd_ptr][W];

    // Store an incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= {push_last, push_data};
        end
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fts_switch.sv
// One node of a fat-tree network: four child ports and one parent port.
// The header (first word) destination byte picks the output. A free output is
// granted to one waiting header by rotating priority, the grant is registered,
// and the output then stays owned until the owner's last word is queued.
// Assumes upstream holds each word stable until accepted.
module fts_switch
    import fts_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8,
    parameter int LEVEL  = 1,
    parameter int PREFIX = 10,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_PORT-1:0]   in_valid,
    input  logic [N_PORT*W-1:0] in_data,
    input  logic [N_PORT-1:0]   in_last,
    output logic [N_PORT-1:0]   in_ready,
    output logic [N_PORT-1:0]   out_valid,
    output logic [N_PORT*W-1:0] out_data,
    output logic [N_PORT-1:0]   out_last,
    input  logic [N_PORT-1:0]   out_ready
);
    port_idx_t         hdr_tgt [N_PORT];
    logic [N_PORT-1:0] in_own;
    port_idx_t         in_tgt  [N_PORT];
    logic [N_PORT-1:0] in_take;
    logic [N_PORT-1:0] in_gnt;
    logic [N_PORT-1:0] locked;
    port_idx_t         owner   [N_PORT];
    logic [N_PORT-1:0] req_m   [N_PORT];
    logic [N_PORT-1:0] gnt_m   [N_PORT];
    logic [N_PORT-1:0] fifo_full;
    logic [N_PORT-1:0] push;
    logic [N_PORT-1:0] push_last;
    logic [W-1:0]      push_data [N_PORT];

    // ---------------- input side ----------------
    for (genvar i = 0; i < N_PORT; i++) begin : g_in
        fts_route_decode #(
            .ADDR_W (ADDR_W),
            .LEVEL  (LEVEL),
            .PREFIX (PREFIX)
        ) u_dec (
            .dest (in_data[i*W +: ADDR_W]),
            .port (hdr_tgt[i])
        );

        // An owning input may pass a word when its output queue has room.
        always_comb begin
            in_ready[i] = in_own[i] && !fifo_full[in_tgt[i]];
            in_take[i]  = in_valid[i] && in_ready[i];
        end

        // Collect the grant addressed to this input from any output.
        always_comb begin
            in_gnt[i] = 1'b0;
            for (int o = 0; o < N_PORT; o++) begin
                in_gnt[i] = in_gnt[i] | gnt_m[o][i];
            end
        end

        // Track ownership: set on grant, cleared when the last word is taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_own[i] <= 1'b0;
                in_tgt[i] <= '0;
            end else if (in_own[i] && in_take[i] && in_last[i]) begin
                in_own[i] <= 1'b0;
            end else if (!in_own[i] && in_gnt[i]) begin
                in_own[i] <= 1'b1;
                in_tgt[i] <= hdr_tgt[i];
            end
        end
    end

    // ---------------- output side ----------------
    for (genvar o = 0; o < N_PORT; o++) begin : g_out
        // Waiting headers that target this output while it is free.
        always_comb begin
            for (int i = 0; i < N_PORT; i++) begin
                req_m[o][i] = in_valid[i] && !in_own[i] &&
                              (hdr_tgt[i] == port_idx_t'(o)) && !locked[o];
            end
        end

        fts_rr_arb #(
            .N (N_PORT)
        ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_m[o]),
            .grant (gnt_m[o])
        );

        // Steer the owning input's word into this output queue.
        always_comb begin
            push[o]      = locked[o] && in_take[owner[o]];
            push_data[o] = in_data[int'(owner[o])*W +: W];
            push_last[o] = in_last[owner[o]];
        end

        // Lock on grant; release once the owner's last word is queued.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                locked[o] <= 1'b0;
                owner[o]  <= '0;
            end else if (locked[o] && push[o] && push_last[o]) begin
                locked[o] <= 1'b0;
            end else if (!locked[o] && (gnt_m[o] != '0)) begin
                locked[o] <= 1'b1;
                owner[o]  <= onehot_to_idx(gnt_m[o]);
            end
        end

        fts_out_fifo #(
            .W     (W),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[o]),
            .push_data (push_data[o]),
            .push_last (push_last[o]),
            .pop_ready (out_ready[o]),
            .valid     (out_valid[o]),
            .data      (out_data[o*W +: W]),
            .last      (out_last[o]),
            .full      (fifo_full[o])
        );
    end
endmodule

// File: rtl/fts_switch_chk.sv
// Assertion checker for fts_switch, attached with bind. Keeps its own
// per-output occupancy counter to bound the queue depth independently.
module fts_switch_chk
    import fts_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_PORT-1:0]   in_ready,
    input logic [N_PORT-1:0]   in_own,
    input port_idx_t           in_tgt [N_PORT],
    input logic [N_PORT-1:0]   locked,
    input port_idx_t           owner  [N_PORT],
    input logic [N_PORT-1:0]   push,
    input logic [N_PORT-1:0]   push_last,
    input logic [N_PORT-1:0]   out_valid,
    input logic [N_PORT*W-1:0] out_data,
    input logic [N_PORT-1:0]   out_last,
    input logic [N_PORT-1:0]   out_ready
);
    int                occ    [N_PORT];
    logic [N_PORT-1:0] own_of [N_PORT];

    // Count words in each queue from the pushes and pops seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < N_PORT; o++) occ[o] <= 0;
        end else begin
            for (int o = 0; o < N_PORT; o++) begin
                occ[o] <= occ[o] + int'(push[o]) - int'(out_valid[o] && out_ready[o]);
            end
        end
    end

    // Which inputs claim each output.
    always_comb begin
        for (int o = 0; o < N_PORT; o++) begin
            for (int i = 0; i < N_PORT; i++) begin
                own_of[o][i] = in_own[i] && (in_tgt[i] == port_idx_t'(o));
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0) && (in_ready == '0));

    for (genvar o = 0; o < N_PORT; o++) begin : g_o
        p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=>
                out_valid[o] && $stable(out_data[o*W +: W]) && $stable(out_last[o]));

        p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            occ[o] <= DEPTH);

        p_no_phantom_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> occ[o] > 0);

        p_lock_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            locked[o] && !(push[o] && push_last[o]) |=> locked[o] && $stable(owner[o]));

        p_one_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_of[o]));
    end

    for (genvar i = 0; i < N_PORT; i++) begin : g_i
        p_route_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_own[i] |-> locked[in_tgt[i]] && (owner[in_tgt[i]] == port_idx_t'(i)));
    end
endmodule

bind fts_switch fts_switch_chk #(
    .W     (W),
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .in_own    (in_own),
    .in_tgt    (in_tgt),
    .locked    (locked),
    .owner     (owner),
    .push      (push),
    .push_last (push_last),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/fts_switch_test.sv
// Self-checking bench: behavioural scoreboard of expected packets per output,
// compared against every output handshake on every clock.
module fts_switch_test;
    localparam int CLK_P = 10;
    localparam int NP    = 5;
    localparam int W     = 32;
    localparam int DEPTH = 4;
    localparam int PFX   = 10;
    localparam int MAXP  = 64;
    localparam int MAXW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_valid;
    logic [NP*W-1:0] in_data;
    logic [NP-1:0]   in_last;
    logic [NP-1:0]   in_ready;
    logic [NP-1:0]   out_valid;
    logic [NP*W-1:0] out_data;
    logic [NP-1:0]   out_last;
    logic [NP-1:0]   out_ready = '0;

    logic            tb_v [NP];
    logic [W-1:0]    tb_d [NP];
    logic            tb_l [NP];

    logic [W-1:0] pw [MAXP][MAXW];
    int  plen [MAXP];
    int  pout [MAXP];
    int  psrc [MAXP];
    int  phdr_cyc [MAXP];
    bit  pdone [MAXP];
    int  nid = 0;
    int  delivered = 0;
    int  cur [NP];
    int  pos [NP];
    bit  block [NP];
    int  acc_cnt [NP];
    int  last_acc_cyc [NP];
    int  q4 [$];
    bit  stress = 0;
    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    fts_switch #(.W(W), .ADDR_W(8), .LEVEL(1), .PREFIX(PFX), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_valid[i]       = tb_v[i];
            in_data[i*W +: W] = tb_d[i];
            in_last[i]        = tb_l[i];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected output from the routing requirements (R2, R3).
    function automatic int route_of(input logic [7:0] d);
        if ((d >> 4) == PFX) return int'((d >> 2) & 8'd3);
        return 4;
    endfunction

    function automatic int mk(input logic [7:0] dest, input int len, input int src);
        int id;
        id = nid;
        nid++;
        plen[id] = len;
        psrc[id] = src;
        pout[id] = route_of(dest);
        for (int k = 0; k < len; k++) begin
            if (k == 0) pw[id][k] = {16'h0000, 8'(id), dest};
            else        pw[id][k] = {8'h5A, 8'(k), 8'(id), 8'(k * 37 + id)};
        end
        return id;
    endfunction

    task automatic send_pkt(input int p, input int id);
        for (int k = 0; k < plen[id]; k++) begin
            @(negedge clk);
            tb_v[p] = 1'b1;
            tb_d[p] = pw[id][k];
            tb_l[p] = (k == plen[id] - 1);
            #2;
            while (!in_ready[p]) begin
                @(negedge clk);
                #2;
            end
            @(posedge clk);
        end
    endtask

    task automatic idle(input int p);
        @(negedge clk);
        tb_v[p] = 1'b0;
        tb_l[p] = 1'b0;
    endtask

    task automatic wait_all();
        while (delivered != nid) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Scoreboard: drive out_ready, then compare every handshake.
    always @(negedge clk) begin
        cyc++;
        for (int o = 0; o < NP; o++) begin
            if (block[o])    out_ready[o] = 1'b0;
            else if (stress) out_ready[o] = ($urandom % 4) != 0;
            else             out_ready[o] = 1'b1;
        end
        #1;
        if (rst_n) begin
            for (int i = 0; i < NP; i++) begin
                if (in_valid[i] && in_ready[i]) begin
                    acc_cnt[i]++;
                    if (in_last[i]) last_acc_cyc[i] = cyc;
                end
            end
            for (int o = 0; o < NP; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    logic [W-1:0] w;
                    w = out_data[o*W +: W];
                    if (cur[o] < 0) begin
                        int id;
                        id = int'(w[15:8]);
                        if (id >= nid || pdone[id]) begin
                            check(0, "R9", "unknown header", w, 0);
                            continue;
                        end
                        check(pout[id] == o, (pout[id] == 4) ? "R3" : "R2",
                              "output port of header", o, pout[id]);
                        cur[o] = id;
                        pos[o] = 0;
                        phdr_cyc[id] = cyc;
                        if (o == 4) q4.push_back(id);
                    end else begin
                        check(int'(w[15:8]) == cur[o], "R5", "packet id mid-packet",
                              w[15:8], cur[o]);
                    end
                    check(w == pw[cur[o]][pos[o]], "R9", "word value", w, pw[cur[o]][pos[o]]);
                    check(out_last[o] == (pos[o] == plen[cur[o]] - 1), "R9", "last flag",
                          out_last[o], pos[o] == plen[cur[o]] - 1);
                    pos[o]++;
                    if (out_last[o] || pos[o] >= plen[cur[o]]) begin
                        pdone[cur[o]] = 1'b1;
                        delivered++;
                        cur[o] = -1;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual %0d delivered expected %0d", delivered, nid);
        finish_up();
    end

    initial begin
        int id;
        int base;
        for (int i = 0; i < NP; i++) begin
            tb_v[i] = 1'b0; tb_d[i] = '0; tb_l[i] = 1'b0;
            cur[i] = -1; pos[i] = 0; block[i] = 1'b0;
            acc_cnt[i] = 0; last_acc_cyc[i] = 0;
        end
        for (int k = 0; k < MAXP; k++) pdone[k] = 1'b0;

        // R1: idle outputs and no ready during and just after reset.
        repeat (3) @(negedge clk);
        #2;
        check(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == '0, "R1", "in_ready in reset", in_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == '0, "R1", "in_ready after reset", in_ready, 0);

        // R2/R3: every input sends to each child and to two non-local addresses.
        for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork
                begin
                    for (int c = 0; c < 4; c++) begin
                        send_pkt(pp, mk(8'hA0 | 8'(c << 2) | 8'(pp & 3), 2 + c, pp));
                    end
                    send_pkt(pp, mk(8'h3C ^ 8'(pp), 3, pp));
                    send_pkt(pp, mk(8'hF1, 1, pp));
                    idle(pp);
                end
            join_none
        end
        wait fork;
        wait_all();
        check(delivered == 30, "R2", "sweep packets delivered", delivered, 30);

        // R4: header of a 10-word packet leaves before its last word is taken.
        id = mk(8'hA9, 10, 0);
        send_pkt(0, id);
        idle(0);
        wait_all();
        check(phdr_cyc[id] < last_acc_cyc[0], "R4", "header cycle vs last-in cycle",
              phdr_cyc[id], last_acc_cyc[0]);

        // R7: stalled output accepts exactly DEPTH words, then holds off.
        block[1] = 1'b1;
        base = acc_cnt[3];
        id = mk(8'hA7, 8, 3);
        fork
            begin send_pkt(3, id); idle(3); end
        join_none
        repeat (20) @(negedge clk);
        #2;
        check(acc_cnt[3] - base == DEPTH, "R7", "words accepted while stalled",
              acc_cnt[3] - base, DEPTH);
        check(out_valid[1] == 1'b1, "R7", "stalled output valid", out_valid[1], 1);
        check(in_ready[3] == 1'b0, "R7", "input held off", in_ready[3], 0);
        block[1] = 1'b0;
        wait fork;
        wait_all();

        // R6: two inputs each stream two packets to the parent port.
        q4.delete();
        fork
            begin
                send_pkt(0, mk(8'h11, 3, 0));
                send_pkt(0, mk(8'h12, 3, 0));
                idle(0);
            end
            begin
                send_pkt(1, mk(8'h13, 3, 1));
                send_pkt(1, mk(8'h14, 3, 1));
                idle(1);
            end
        join
        wait_all();
        check(q4.size() == 4, "R6", "packets on up port", q4.size(), 4);
        for (int k = 1; k < 4 && k < q4.size(); k++) begin
            check(psrc[q4[k]] != psrc[q4[k-1]], "R6", "source alternates",
                  psrc[q4[k]], 1 - psrc[q4[k-1]]);
        end

        // R8: single-word packets mixed with a long packet on the same output.
        base = delivered;
        fork
            begin
                for (int k = 0; k < 6; k++) begin
                    send_pkt(2, mk((k % 2 == 0) ? 8'hA1 : 8'h22, 1, 2));
                end
                idle(2);
            end
            begin send_pkt(0, mk(8'hA2, 4, 0)); idle(0); end
        join
        wait_all();
        check(delivered - base == 7, "R8", "single-word burst delivered", delivered - base, 7);

        // R5/R9 stress: random stalls, destinations and lengths.
        stress = 1'b1;
        for (int p = 0; p < NP; p++) begin
            automatic int pp = p;
            fork
                begin
                    for (int k = 0; k < 3; k++) begin
                        logic [7:0] d;
                        d = ($urandom % 2 == 0) ? (8'hA0 | 8'($urandom % 16)) : 8'($urandom);
                        send_pkt(pp, mk(d, 1 + int'($urandom % 8), pp));
                    end
                    idle(pp);
                end
            join_none
        end
        wait fork;
        wait_all();
        stress = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check(delivered == nid, "R9", "all packets delivered", delivered, nid);
        check(out_valid == '0, "R5", "outputs drained", out_valid, 0);
        finish_up();
    end
endmodule